// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block runs single read and write cycles on an asynchronous, byte-wide static RAM with a 19-bit address. On the memory side it drives three active-low strobes (chip select, output enable, write strobe), the address, and a data bus that is split into an outgoing byte, an incoming byte and an enable for the controller's own pad drivers. On the user side it offers a request/ready handshake with an address, a write byte, a write flag, and a returned read byte marked by a one-clock valid pulse.

The memory has no clock, so every timing minimum is met by counting system clocks. Each minimum is a parameter in nanoseconds, alongside the clock period. A phase lasts the ceiling of its time divided by the period, and never less than one clock. Writes are timed by the write strobe with output enable held high. Reads are timed by output enable. The controller turns its own drivers on only after the memory's output turn-off window has passed.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever no cycle is in progress, `ready_o` is 1, all three strobes are high (1), and `mem_dq_oe_o` is 0.
- R2: A cycle starts on a clock edge where `req_i` and `ready_o` are both 1. `ready_o` is 0 for every clock of the cycle, and requests seen while it is 0 are not taken.
- R3: The address and write byte are latched when a cycle starts. `mem_addr_o` is constant for as long as chip select stays low.
- R4: A read (`we_i`=0) holds chip select and output enable low and the write strobe high for RD clocks, where RD = max(ceil(Tacc/P), ceil(Toe/P), ceil(Tcyc/P)). With the defaults (P=10, Tacc=70, Toe=35, Tcyc=70) RD is 7. The byte on `mem_dq_i` is captured at the edge that ends this phase. `rdata_o` then holds it and `rvalid_o` is 1 for exactly one clock, in the first idle clock.
- R5: A write (`we_i`=1) keeps output enable high for the whole cycle and holds chip select and the write strobe low for WL consecutive clocks. WL = max(ceil(Twp/P), ceil(Tas/P), TURN+DS, ceil(Tcyc/P)-1). With the defaults WL is 6.
- R6: During a write, `mem_dq_oe_o` stays 0 for the first TURN = ceil(Thz/P) clocks of the write-strobe-low period (3 by default). It then rises and presents the latched byte for the remaining WL-TURN clocks. That is at least DS = ceil(Tds/P) clocks (3 by default) before the strobe rises.
- R7: After the write strobe rises, chip select stays low and the drivers stay on for one more clock. Both are then released on the same edge.
- R8: Chip-select falling edges are at least Tcyc apart. A read occupies RD clocks and a write WL+1 clocks, and at least one idle clock follows each cycle.
- R9: `mem_dq_oe_o` is never 1 while output enable is low, nor within Thz after output enable rises or the write strobe falls.
- R10: A write produces no `rvalid_o` pulse, and a later read of the same address returns the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Cycle request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Byte to write |
| ready_o | output | 1 | Idle, a request will be taken |
| rdata_o | output | 8 | Last byte read |
| rvalid_o | output | 1 | One-clock pulse, `rdata_o` is new |
| mem_addr_o | output | 19 | Memory address |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 8 | Byte read from the memory bus |

## Verification
A sequencer in the wrong state shows up at the strobe pins in the very next clock. A phase counter loaded with the wrong count shows up as a strobe edge one or more clocks early or late, which a per-clock comparison of the strobes catches at once. A driver enable switched on too early shows up as overlap with the memory's turn-off window on the clock of its rising edge. A wrong capture edge or a lost write byte only shows up later, at the read-back of that address, as a wrong `rdata_o`. For that reason, every written address is read again.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SRAM access controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WR_TURN = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_WR_REC  = 3'd4
    } sram_state_e;

    // Whole clocks covering a time, never fewer than one.
    function automatic int unsigned ns_to_clks(int unsigned t_ns, int unsigned period_ns);
        int unsigned q;
        q = (t_ns + period_ns - 1) / period_ns;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one phase of a memory cycle.
// A load with value N makes last_o high in the N-th clock of the phase.
// Assumes N >= 1 whenever load_i is pulsed.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
// Cycle sequencer: walks read and write phases and registers the memory
// strobes from the next state, so every pin toggles only at a clock edge.
// Assumes the phase timer reports last_i in the final clock of each phase.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned RD_CLKS    = 7,
    parameter int unsigned TURN_CLKS  = 3,
    parameter int unsigned WDATA_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic             last_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             ready_o,
    output logic             ce_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             dq_oe_o
);
    sram_state_e state_q, state_d;

    // Next-state and timer-load decisions.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        capture_o  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    load_o = 1'b1;
                    if (we_i) begin
                        state_d    = ST_WR_TURN;
                        load_val_o = CNT_W'(TURN_CLKS);
                    end else begin
                        state_d    = ST_READ;
                        load_val_o = CNT_W'(RD_CLKS);
                    end
                end
            end
            ST_READ: begin
                if (last_i) begin
                    state_d   = ST_IDLE;
                    capture_o = 1'b1;
                end
            end
            ST_WR_TURN: begin
                if (last_i) begin
                    state_d    = ST_WR_DATA;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(WDATA_CLKS);
                end
            end
            ST_WR_DATA: begin
                if (last_i)
                    state_d = ST_WR_REC;
            end
            ST_WR_REC: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign accept_o = ready_o && req_i;

    // State register and strobes registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n_o  <= 1'b1;
            oe_n_o  <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
        end else begin
            state_q <= state_d;
            ce_n_o  <= (state_d == ST_IDLE);
            oe_n_o  <= (state_d != ST_READ);
            we_n_o  <= !((state_d == ST_WR_TURN) || (state_d == ST_WR_DATA));
            dq_oe_o <= (state_d == ST_WR_DATA) || (state_d == ST_WR_REC);
        end
    end

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
// Address and data registers between the user port and the memory pins.
// Latches address and write byte when a cycle starts; captures the read
// byte on the sequencer's capture pulse and flags it for one clock.
module sram_dq_path #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    // Hold the request fields for the full memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            mem_dq_o   <= '0;
        end else if (accept_i) begin
            mem_addr_o <= addr_i;
            mem_dq_o   <= wdata_i;
        end
    end

    // Sample the memory bus at the end of a read and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= capture_i;
            if (capture_i)
                rdata_o <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM access controller.
// Converts clocked single-byte requests into strobe sequences that meet
// the memory's nanosecond minimums by clock counting. Assumes the memory
// bus is split at the pads into mem_dq_o / mem_dq_i with mem_dq_oe_o.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W           = 19,
    parameter int unsigned DATA_W           = 8,
    parameter int unsigned CLK_PERIOD_NS    = 10,
    parameter int unsigned T_CYCLE_NS       = 70,
    parameter int unsigned T_ADDR_ACC_NS    = 70,
    parameter int unsigned T_OE_ACC_NS      = 35,
    parameter int unsigned T_WE_PULSE_NS    = 55,
    parameter int unsigned T_ADDR_SETUP_NS  = 60,
    parameter int unsigned T_DATA_SETUP_NS  = 25,
    parameter int unsigned T_BUS_RELEASE_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned CYC_CLKS   = ns_to_clks(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned RD_CLKS    = max_u(max_u(ns_to_clks(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                                     ns_to_clks(T_OE_ACC_NS, CLK_PERIOD_NS)),
                                               CYC_CLKS);
    localparam int unsigned TURN_CLKS  = ns_to_clks(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned DS_CLKS    = ns_to_clks(T_DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned WL_CLKS    = max_u(max_u(ns_to_clks(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                                     ns_to_clks(T_ADDR_SETUP_NS, CLK_PERIOD_NS)),
                                               max_u(TURN_CLKS + DS_CLKS, CYC_CLKS - 1));
    localparam int unsigned WDATA_CLKS = WL_CLKS - TURN_CLKS;
    localparam int unsigned CNT_W      = $clog2(max_u(RD_CLKS, WL_CLKS) + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             last;
    logic             accept;
    logic             capture;

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .last_o     (last)
    );

    sram_ctrl_seq #(
        .CNT_W      (CNT_W),
        .RD_CLKS    (RD_CLKS),
        .TURN_CLKS  (TURN_CLKS),
        .WDATA_CLKS (WDATA_CLKS)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .we_i       (we_i),
        .last_i     (last),
        .load_o     (load),
        .load_val_o (load_val),
        .accept_o   (accept),
        .capture_o  (capture),
        .ready_o    (ready_o),
        .ce_n_o     (mem_ce_n_o),
        .oe_n_o     (mem_oe_n_o),
        .we_n_o     (mem_we_n_o),
        .dq_oe_o    (mem_dq_oe_o)
    );

    sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .capture_i  (capture),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .mem_dq_i   (mem_dq_i),
        .mem_addr_o (mem_addr_o),
        .mem_dq_o   (mem_dq_o),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_ctrl, attached by bind. Watches only the
// top-level pins and keeps its own clock counters for timing windows.
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W           = 19,
    parameter int unsigned CLK_PERIOD_NS    = 10,
    parameter int unsigned T_CYCLE_NS       = 70,
    parameter int unsigned T_ADDR_ACC_NS    = 70,
    parameter int unsigned T_OE_ACC_NS      = 35,
    parameter int unsigned T_WE_PULSE_NS    = 55,
    parameter int unsigned T_ADDR_SETUP_NS  = 60,
    parameter int unsigned T_BUS_RELEASE_NS = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              ready_o,
    input logic              rvalid_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic              mem_dq_oe_o
);
    localparam int unsigned OE_MIN  = max_u(ns_to_clks(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                            ns_to_clks(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int unsigned WE_MIN  = max_u(ns_to_clks(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                            ns_to_clks(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned HZ_MIN  = ns_to_clks(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned SAT     = 1000;

    int unsigned oe_low_cnt, we_low_cnt, quiet_cnt;
    logic        we_n_prev;

    // Count clocks of output-enable low, write-strobe low, and bus quiet time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_low_cnt <= 0;
            we_low_cnt <= 0;
            quiet_cnt  <= SAT;
            we_n_prev  <= 1'b1;
        end else begin
            we_n_prev  <= mem_we_n_o;
            oe_low_cnt <= mem_oe_n_o ? 0 : oe_low_cnt + 1;
            we_low_cnt <= mem_we_n_o ? 0 : we_low_cnt + 1;
            if (!mem_oe_n_o)
                quiet_cnt <= 0;
            else if (we_n_prev && !mem_we_n_o)
                quiet_cnt <= 1;
            else if (quiet_cnt < SAT)
                quiet_cnt <= quiet_cnt + 1;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> !ready_o);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o));

    a_r4_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    a_r4_late_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_o) |-> (oe_low_cnt >= OE_MIN));

    a_r5_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o);

    a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_low_cnt >= WE_MIN));

    a_r6_turn_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (quiet_cnt >= HZ_MIN));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe_o) |-> (mem_ce_n_o && $past(mem_we_n_o)));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o);

    a_r10_no_valid_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !rvalid_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W           (ADDR_W),
    .CLK_PERIOD_NS    (CLK_PERIOD_NS),
    .T_CYCLE_NS       (T_CYCLE_NS),
    .T_ADDR_ACC_NS    (T_ADDR_ACC_NS),
    .T_OE_ACC_NS      (T_OE_ACC_NS),
    .T_WE_PULSE_NS    (T_WE_PULSE_NS),
    .T_ADDR_SETUP_NS  (T_ADDR_SETUP_NS),
    .T_BUS_RELEASE_NS (T_BUS_RELEASE_NS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ready_o     (ready_o),
    .rvalid_o    (rvalid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: per-clock expected pin stream, behavioural memory with
// nanosecond timing checks, and a read-back scoreboard.
module sram_ctrl_tb_top;

    // Expected phase lengths for 10 ns clock, worked out from the requirements.
    localparam int RD   = 7;   // max(70,35,70)/10
    localparam int TURN = 3;   // 25/10 rounded up
    localparam int WL   = 6;   // max(55/10->6, 60/10->6, 3+3, 7-1)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready_o, rvalid_o, mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o;
    logic [7:0]  rdata_o, mem_dq_o, mem_dq_i;
    logic [18:0] mem_addr_o;

    always #5 clk = ~clk;

    sram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .mem_addr_o(mem_addr_o), .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_we_n_o(mem_we_n_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
        .mem_dq_i(mem_dq_i)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(string tag, bit ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mdl_mem [int];
    int         wr_evt = 0;
    longint     t_cs = -1000, t_wel = -1000, t_oe_fall = -1000, t_oe_rise = -1000, t_dq = -1000;

    function automatic logic [7:0] init_byte(logic [18:0] a);
        return a[7:0] ^ {1'b0, a[18:12]} ^ 8'h3C;
    endfunction

    always @(mem_ce_n_o or mem_oe_n_o or mem_we_n_o or mem_addr_o or wr_evt) begin
        if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o)
            mem_dq_i = mdl_mem.exists(int'(mem_addr_o)) ? mdl_mem[int'(mem_addr_o)] : init_byte(mem_addr_o);
        else
            mem_dq_i = 8'hzz;
    end

    always @(negedge mem_ce_n_o) begin
        if (rst_n) check("R8 cycle spacing", ($time - t_cs) >= 70, $time - t_cs, 70);
        t_cs = $time;
    end
    always @(negedge mem_oe_n_o) t_oe_fall = $time;
    always @(posedge mem_oe_n_o) t_oe_rise = $time;
    always @(negedge mem_we_n_o) t_wel = $time;
    always @(posedge mem_dq_oe_o) begin
        t_dq = $time;
        check("R9 bus turn", mem_oe_n_o && ($time - t_oe_rise) >= 25 && ($time - t_wel) >= 25,
              $time - t_wel, 25);
    end
    always @(posedge mem_we_n_o) begin
        if (rst_n && !mem_ce_n_o) begin
            check("R5 strobe width", ($time - t_wel) >= 55, $time - t_wel, 55);
            check("R5 addr setup", ($time - t_cs) >= 60, $time - t_cs, 60);
            check("R6 data setup", mem_dq_oe_o && ($time - t_dq) >= 25, $time - t_dq, 25);
            mdl_mem[int'(mem_addr_o)] = mem_dq_o;
            wr_evt++;
        end
    end
    always @(posedge rvalid_o) begin
        check("R4 access time", ($time - t_oe_fall) >= 35 && ($time - t_cs) >= 70, $time - t_cs, 70);
    end

    // ---------------- per-clock reference stream ----------------
    typedef struct {
        bit ce_n, oe_n, we_n, dq_oe, rdy, rv;
        string tag;
    } exp_t;

    exp_t        eq[$];
    logic [7:0]  rq[$];
    logic [7:0]  sb [int];
    logic [18:0] cur_addr;
    logic [7:0]  cur_wdata;
    bit          acc_pend = 0;
    bit          mon_on = 0;

    function automatic exp_t mk(bit c, bit o, bit w, bit d, bit r, bit v, string t);
        exp_t e;
        e.ce_n = c; e.oe_n = o; e.we_n = w; e.dq_oe = d; e.rdy = r; e.rv = v; e.tag = t;
        return e;
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            logic [5:0] act, expv;
            e = (eq.size() > 0) ? eq.pop_front() : mk(1, 1, 1, 0, 1, 0, "R1 idle");
            act  = {mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, ready_o, rvalid_o};
            expv = {e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.rdy, e.rv};
            check(e.tag, act === expv, act, expv);
            if (!mem_ce_n_o)
                check("R3 address", mem_addr_o === cur_addr, mem_addr_o, cur_addr);
            if (mem_dq_oe_o)
                check("R6 write byte", mem_dq_o === cur_wdata, mem_dq_o, cur_wdata);
            if (rvalid_o) begin
                logic [7:0] x;
                x = (rq.size() > 0) ? rq.pop_front() : 8'hxx;
                check("R10 read back", rdata_o === x, rdata_o, x);
            end
            acc_pend = req && ready_o;
            if (acc_pend) begin
                cur_addr  = addr;
                cur_wdata = wdata;
                if (we) begin
                    sb[int'(addr)] = wdata;
                    for (int i = 0; i < TURN; i++) eq.push_back(mk(0, 1, 0, 0, 0, 0, "R2/R6 turn"));
                    for (int i = TURN; i < WL; i++) eq.push_back(mk(0, 1, 0, 1, 0, 0, "R5/R6 drive"));
                    eq.push_back(mk(0, 1, 1, 1, 0, 0, "R7 hold"));
                    eq.push_back(mk(1, 1, 1, 0, 1, 0, "R7/R10 release"));
                end else begin
                    rq.push_back(sb.exists(int'(addr)) ? sb[int'(addr)] : init_byte(addr));
                    for (int i = 0; i < RD; i++) eq.push_back(mk(0, 0, 1, 0, 0, 0, "R2/R4 read"));
                    eq.push_back(mk(1, 1, 1, 0, 1, 1, "R4 valid"));
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(bit w, logic [18:0] a, logic [7:0] d);
        req = 1'b1; we = w; addr = a; wdata = d;
        forever begin
            @(posedge clk);
            if (acc_pend) break;
        end
        #2;
        req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        logic [31:0] lcg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, ready_o, rvalid_o} === 6'b111010,
              {mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, ready_o, rvalid_o}, 6'b111010);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(3);
        op(0, 19'h00000, 8'h00);
        op(0, 19'h7FFFF, 8'h00);
        idle(2);
        op(1, 19'h00005, 8'hA5);
        op(0, 19'h00005, 8'h00);
        op(1, 19'h7FFFF, 8'hFF);
        op(1, 19'h00000, 8'h00);
        idle(4);
        op(0, 19'h00000, 8'h00);
        op(0, 19'h7FFFF, 8'h00);
        // R2: request held through a busy cycle is taken only when idle again
        op(1, 19'h12345, 8'h5A);
        op(1, 19'h12345, 8'hC3);
        op(0, 19'h12345, 8'h00);
        lcg = 32'h1F2E3D4C;
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            op(lcg[31], {lcg[20:16], lcg[13:0]} & 19'h0003F, lcg[9:2]);
            if (lcg[5]) idle(int'(lcg[4:3]));
        end
        for (int a = 0; a < 64; a += 5) op(0, 19'(a), 8'h00);
        idle(20);
        check("R10 all reads returned", rq.size() == 0, rq.size(), 0);
        check("R1 stream drained", eq.size() == 0, eq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule